// File: doc/BRIEF.md
# Polled Device Port with Ready Flag

This block is the device end of a memory-mapped input/output path. A processor reaches it through a simple load/store bus that completes in one cycle. The port answers only inside a reserved window at the top of the 32-bit address space, and no memory is present there. Inside the window sit two words. The status/enable word holds a ready flag and an interrupt-enable bit. The transfer word holds one byte.

The attached device raises the ready flag in two cases: when it has put a byte into the transfer word (input), or when it is free to take the next byte (output). The processor can poll the flag, or it can enable the interrupt line and wait for a level request. Any processor load or store to the transfer word moves the byte and drops the flag as a side effect. A pulse tells the device that the access took place.

Top module: `polled_dev_port`

## Requirements
- R1: After reset the ready flag, the interrupt enable, the transfer byte, `irq` and `dev_data_out` are all 0.
- R2: A cycle with `dev_raise` high sets the ready flag from the next cycle on. A load of the status word at 0xFFFF0000 then returns ready in bit 0 and interrupt enable in bit 1, with all other bits 0.
- R3: A load of the transfer word at 0xFFFF0004 returns the stored byte zero-extended to 32 bits in the same cycle, and clears the ready flag at the next edge.
- R4: A store to 0xFFFF0004 writes the low 8 bits of `bus_wdata` into the transfer byte (seen on `dev_data_out`) and clears ready. `dev_xfer` is high in exactly those cycles that load or store 0xFFFF0004.
- R5: A store to 0xFFFF0000 sets interrupt enable from `bus_wdata` bit 1 and ignores `bus_wdata` bit 0, so ready is not changed by it.
- R6: `irq` is high exactly when ready and interrupt enable are both 1, and it stays high for as long as both hold.
- R7: When `dev_raise` coincides with a transfer-word access, ready is 1 afterwards. If `dev_fill` is also high, the transfer byte takes `dev_byte_in` rather than the stored value.
- R8: A load or store whose address bits [31:16] are not all ones leaves every register unchanged, keeps `dev_sel` low and returns 0 on `bus_rdata`.
- R9: `dev_sel` is high in exactly those cycles with a load or store whose address lies in 0xFFFF0000 to 0xFFFFFFFF.
- R10: A load or store to any other offset inside the window changes no register and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Load request this cycle |
| bus_wr | input | 1 | Store request this cycle |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the cycle of the load |
| dev_sel | output | 1 | Access falls in the device window |
| dev_raise | input | 1 | Device sets the ready flag |
| dev_fill | input | 1 | With dev_raise, load dev_byte_in into the transfer byte |
| dev_byte_in | input | 8 | Byte offered by the device |
| dev_data_out | output | 8 | Current transfer byte |
| dev_xfer | output | 1 | Processor accessed the transfer word this cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit transfer byte and a window defined by the top 16 address bits. With an 8-bit byte, the discarded upper store bits can be observed. The 16-bit window also puts unmapped in-window offsets and near-miss outside addresses within reach of random address choices. Random loads, stores and device raises hit the same-cycle collisions between the device and the processor often, so the set-wins rule is exercised far more than the directed cases alone would manage.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_STAT = 2'd1,
        HIT_XFER = 2'd2,
        HIT_HOLE = 2'd3
    } hit_e;

    localparam int RDY_POS = 0;
    localparam int IEN_POS = 1;
endpackage

// File: rtl/pdp_decode.sv
module pdp_decode
    import pdp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 16,
    parameter int STAT_OFF = 0,
    parameter int XFER_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              sel,
    output hit_e              hit
);
    localparam int OFF_W = ADDR_W - WIN_BITS;

    logic             in_win;
    logic [OFF_W-1:0] offset;

    always_comb begin
        in_win = &bus_addr[ADDR_W-1 -: WIN_BITS];
        offset = bus_addr[OFF_W-1:0];
        sel    = in_win && (bus_rd || bus_wr);
        hit    = HIT_NONE;
        if (sel) begin
            if (offset == OFF_W'(STAT_OFF))      hit = HIT_STAT;
            else if (offset == OFF_W'(XFER_OFF)) hit = HIT_XFER;
            else                                 hit = HIT_HOLE;
        end
    end

    // R9: a select never appears without a bus request
    p_sel_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (bus_rd || bus_wr));
    // R8: no register hit reported while the select is low
    p_no_hit_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (hit == HIT_NONE));
endmodule

// File: rtl/pdp_regs.sv
module pdp_regs
    import pdp_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hit_e              hit,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              dev_raise,
    input  logic              dev_fill,
    input  logic [DATA_W-1:0] dev_byte_in,
    output logic              ready,
    output logic              irq_en,
    output logic [DATA_W-1:0] data,
    output logic              xfer
);
    typedef struct packed {
        logic              ready;
        logic              ien;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;
    logic   xfer_hit;

    generate
        if (DATA_W < BUS_W) begin : g_spare
            logic unused_wbits;
            assign unused_wbits = ^bus_wdata[BUS_W-1:DATA_W];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        xfer_hit = (hit == HIT_XFER) && (bus_rd || bus_wr);
        if (hit == HIT_STAT && bus_wr) begin
            st_d.ien = bus_wdata[IEN_POS];
        end
        if (xfer_hit) begin
            st_d.ready = 1'b0;
            if (bus_wr) st_d.data = bus_wdata[DATA_W-1:0];
        end
        if (dev_raise) begin
            st_d.ready = 1'b1;
            if (dev_fill) st_d.data = dev_byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready  = st_q.ready;
    assign irq_en = st_q.ien;
    assign data   = st_q.data;
    assign xfer   = xfer_hit;

    // R7: a device raise always leaves ready set
    p_raise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_raise |=> ready);
    // R3: a transfer-word access without a raise clears ready
    p_access_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == HIT_XFER && !dev_raise) |=> !ready);
    // R5: a status store never moves ready
    p_stat_keeps_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == HIT_STAT && !dev_raise) |=> $stable(ready));
    // R8: without a hit or a device fill, the byte holds
    p_data_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != HIT_XFER && !(dev_raise && dev_fill)) |=> $stable(data));
    // R10: unmapped in-window offsets leave the enable alone
    p_hole_keeps_ien_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != HIT_STAT) |=> $stable(irq_en));
endmodule

// File: rtl/pdp_rdmux.sv
module pdp_rdmux
    import pdp_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8
) (
    input  hit_e              hit,
    input  logic              bus_rd,
    input  logic              ready,
    input  logic              irq_en,
    input  logic [DATA_W-1:0] data,
    output logic [BUS_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            unique case (hit)
                HIT_STAT: begin
                    rdata[RDY_POS] = ready;
                    rdata[IEN_POS] = irq_en;
                end
                HIT_XFER: rdata[DATA_W-1:0] = data;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/polled_dev_port.sv
module polled_dev_port
    import pdp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BUS_W    = 32,
    parameter int DATA_W   = 8,
    parameter int WIN_BITS = 16,
    parameter int STAT_OFF = 0,
    parameter int XFER_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              dev_sel,
    input  logic              dev_raise,
    input  logic              dev_fill,
    input  logic [DATA_W-1:0] dev_byte_in,
    output logic [DATA_W-1:0] dev_data_out,
    output logic              dev_xfer,
    output logic              irq
);
    hit_e              hit;
    logic              ready;
    logic              irq_en;
    logic [DATA_W-1:0] data;

    pdp_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
        .STAT_OFF(STAT_OFF), .XFER_OFF(XFER_OFF)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .sel(dev_sel), .hit(hit)
    );

    pdp_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hit(hit), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .dev_raise(dev_raise), .dev_fill(dev_fill),
        .dev_byte_in(dev_byte_in), .ready(ready), .irq_en(irq_en),
        .data(data), .xfer(dev_xfer)
    );

    pdp_rdmux #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_rd (
        .hit(hit), .bus_rd(bus_rd), .ready(ready), .irq_en(irq_en),
        .data(data), .rdata(bus_rdata)
    );

    assign irq          = ready && irq_en;
    assign dev_data_out = data;

    // R6: the request line implies a pending ready flag
    p_irq_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_rdata[RDY_POS] || !(bus_rd && hit == HIT_STAT)));
    // R4: the transfer pulse only accompanies a selected access
    p_xfer_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_xfer |-> dev_sel);
endmodule

// File: tb/sim_polled_dev_port.sv
module sim_polled_dev_port;
    localparam logic [31:0] A_STAT = 32'hFFFF_0000;
    localparam logic [31:0] A_XFER = 32'hFFFF_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_sel, dev_raise = 1'b0, dev_fill = 1'b0;
    logic [7:0]  dev_byte_in = '0, dev_data_out;
    logic        dev_xfer, irq;

    int total = 0, bad = 0;
    bit done = 0;
    logic       m_rdy = 0, m_ien = 0;
    logic [7:0] m_dat = 0;
    logic [31:0] got_rd;

    always #2 clk = ~clk;

    polled_dev_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_sel(dev_sel), .dev_raise(dev_raise), .dev_fill(dev_fill),
        .dev_byte_in(dev_byte_in), .dev_data_out(dev_data_out),
        .dev_xfer(dev_xfer), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [31:0] a);
        return a[31:16] == 16'hFFFF;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic rd, input logic [31:0] a);
        if (!rd) return '0;
        if (a == A_STAT) return {30'd0, m_ien, m_rdy};
        if (a == A_XFER) return {24'd0, m_dat};
        return '0;
    endfunction

    task automatic step(input logic rd, input logic wr, input logic [31:0] a,
                        input logic [31:0] wd, input logic rz, input logic fl,
                        input logic [7:0] bi);
        logic [31:0] er;
        string rtag;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        dev_raise = rz; dev_fill = fl; dev_byte_in = bi;
        #1;
        er = exp_rdata(rd, a);
        rtag = !in_win(a) ? "R8" : (a == A_STAT) ? "R2" : (a == A_XFER) ? "R3" : "R10";
        got_rd = bus_rdata;
        chk(bus_rdata == er, rtag, bus_rdata, er);
        chk(dev_sel == (in_win(a) && (rd || wr)), "R9", 32'(dev_sel), 32'(in_win(a) && (rd || wr)));
        chk(dev_xfer == (a == A_XFER && (rd || wr)), "R4", 32'(dev_xfer), 32'(a == A_XFER && (rd || wr)));
        chk(irq == (m_rdy && m_ien), "R6", 32'(irq), 32'(m_rdy && m_ien));
        chk(dev_data_out == m_dat, "R4", 32'(dev_data_out), 32'(m_dat));
        @(posedge clk);
        if (a == A_STAT && wr) m_ien = wd[1];
        if (a == A_XFER && (rd || wr)) begin
            m_rdy = 0;
            if (wr) m_dat = wd[7:0];
        end
        if (rz) begin
            m_rdy = 1;
            if (fl) m_dat = bi;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk(irq == 0, "R1", 32'(irq), 0);
        chk(dev_data_out == 0, "R1", 32'(dev_data_out), 0);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 0, "R1", got_rd, 0);
        // R2: device raise with a byte, visible in the status word
        step(0, 0, 0, 0, 1, 1, 8'hA5);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h1, "R2", got_rd, 32'h1);
        // R3: load moves the byte and clears ready
        step(1, 0, A_XFER, 0, 0, 0, 0);
        chk(got_rd == 32'hA5, "R3", got_rd, 32'hA5);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h0, "R3", got_rd, 0);
        // R5: bit 0 of a status store is ignored, bit 1 enables
        step(0, 1, A_STAT, 32'h3, 0, 0, 0);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h2, "R5", got_rd, 32'h2);
        // R6: ready with enable raises the level request
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(irq == 1, "R6", 32'(irq), 1);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(irq == 1, "R6", 32'(irq), 1);
        // R4: store takes the low byte and drops ready
        step(0, 1, A_XFER, 32'h1234_5678, 0, 0, 0);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h2, "R4", got_rd, 32'h2);
        chk(dev_data_out == 8'h78, "R4", 32'(dev_data_out), 32'h78);
        // R7: raise with fill beats a colliding store
        step(0, 1, A_XFER, 32'h99, 1, 1, 8'h3C);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h3, "R7", got_rd, 32'h3);
        chk(dev_data_out == 8'h3C, "R7", 32'(dev_data_out), 32'h3C);
        step(1, 0, A_XFER, 0, 1, 0, 0);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h3, "R7", got_rd, 32'h3);
        // R8: near-miss addresses outside the window
        step(0, 1, 32'h7FFF_0000, 32'h0, 0, 0, 0);
        step(0, 1, 32'hFFFE_0004, 32'h55, 0, 0, 0);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h3, "R8", got_rd, 32'h3);
        chk(dev_data_out == 8'h3C, "R8", 32'(dev_data_out), 32'h3C);
        // R10: unmapped in-window offset
        step(0, 1, 32'hFFFF_0008, 32'h0, 0, 0, 0);
        step(1, 0, 32'hFFFF_0008, 0, 0, 0, 0);
        chk(got_rd == 0, "R10", got_rd, 0);
        step(1, 0, A_STAT, 0, 0, 0, 0);
        chk(got_rd == 32'h3, "R10", got_rd, 32'h3);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            int k = $urandom_range(0, 5);
            int op = $urandom_range(0, 2);
            case (k)
                0, 1:    a = A_STAT;
                2, 3:    a = A_XFER;
                4:       a = {16'hFFFF, 16'($urandom_range(8, 65535))};
                default: a = {16'($urandom_range(0, 65534)), 16'($urandom_range(0, 8))};
            endcase
            step(op == 1, op == 2, a, $urandom, ($urandom_range(0, 3) == 0),
                 $urandom_range(0, 1) == 1, 8'($urandom));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule